// File: doc/BRIEF.md
# Register-Add Fetch/Execute Core

This block is a small multi-cycle processor that runs one instruction at a time through a fixed loop of states. In `ST_FETCH` it requests the word at the program counter from an instruction memory and waits for `imem_ready`. In `ST_ADVANCE` it steps the program counter by 4. In `ST_DECODE` it decodes the word and reads both source registers. In `ST_EXECUTE` it writes the destination and returns to fetch. Every instruction is one 32-bit word. The only instruction it accepts is the register-format add: the opcode (bits 31..26) is 0 and the function code (bits 5..0) is 32. The source fields are bits 25..21 and 20..16, the destination field is bits 15..11, and the shift-amount field is bits 10..6, which add ignores.

There are two terminal states, and only reset leaves them. `ST_HALTED` is entered from `ST_DECODE` when the word is anything other than an add. `ST_FAULTED` is entered from `ST_FETCH` when the program counter has bit 31 set, because user code may only run in the lower 2 GB. In that case no request is issued. The core has 32 general registers of 32 bits, a program counter, and hi/lo registers that can be read but that no instruction modifies.

A small inspection port gives the surrounding system access to architectural state. It reads any general register, the program counter, hi and lo, and it writes a general register or the program counter. It is used to load operands and starting addresses while the core waits in fetch with ready held low.

Top module: `mini_rcore`

## Requirements
- R1: The reset state is as follows. The program counter is 0, halt and fault are low, all general registers and hi/lo read 0, and the core requests address 0 in `ST_FETCH`.
- R2: A word with opcode 0 and function 32 writes rs + rt into rd. Word 0x01095020 writes register 8 + register 9 into register 10.
- R3: rd may equal rs and/or rt. The sum uses the values held before the write.
- R4: The sum wraps modulo 2^32 with no trap, and the shift-amount field bits 10..6 has no effect on add.
- R5: The program counter advances by exactly 4 per fetched word. While `imem_req` is high and `imem_ready` is low, the program counter and registers hold.
- R6: Register 0 always reads 0. Adds and inspection writes that target it are ignored.
- R7: A nonzero opcode, or opcode 0 with a function other than 32, moves the core to `ST_HALTED`. The destination is left unchanged, the program counter points past that word, halt stays high, and no further request is made.
- R8: When the program counter has bit 31 set in `ST_FETCH`, the core moves to `ST_FAULTED` without requesting. Fault stays high, halt stays low, and no further request is made.
- R9: hi and lo read 0 and are never modified by instruction execution.
- R10: Inspection select encoding: 0..31 is the general registers, 32 is the program counter, 33 is hi, 34 is lo. Reads are combinational. A write with `dbg_we` high takes effect at the next clock edge. The memory word is selected by `imem_addr`, which is the byte address held in the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | 32 | Byte address of requested word |
| imem_ready | input | 1 | Memory has the requested word on imem_rdata |
| imem_rdata | input | 32 | Instruction word |
| dbg_we | input | 1 | Inspection write strobe |
| dbg_sel | input | 6 | Inspection select (see R10) |
| dbg_wdata | input | 32 | Inspection write data |
| dbg_rdata | output | 32 | Inspection read data |
| halt | output | 1 | Core stopped on a non-add word |
| fault | output | 1 | Core stopped on a fetch above 2 GB |

## Verification
The assertions on program-counter movement assume two things. First, inspection writes reach the core only while it is idle in `ST_FETCH` with ready low, or after it has stopped. Second, the memory's data is valid in the cycle in which it raises ready. The bench keeps to both. It drives ready low whenever it loads registers or the program counter through the inspection port, and it serves every word combinationally from its own array. Reset is held for several cycles before each scenario, so no property sees a state that reset did not define.

// File: rtl/mini_rcore_pkg.sv
package mini_rcore_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_ADVANCE,
        ST_DECODE,
        ST_EXECUTE,
        ST_HALTED,
        ST_FAULTED
    } core_state_e;

    localparam int          INSTR_W    = 32;
    localparam int          FIELD_W    = 5;
    localparam logic [5:0]  OPC_REGFMT = 6'd0;
    localparam logic [5:0]  FUNC_ADD   = 6'd32;
    localparam int          PC_STEP    = 4;

endpackage

// File: rtl/mini_rcore_decode.sv
module mini_rcore_decode
    import mini_rcore_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [FIELD_W-1:0] rs_idx,
    output logic [FIELD_W-1:0] rt_idx,
    output logic [FIELD_W-1:0] rd_idx,
    output logic               is_add
);

    logic [5:0] opcode;
    logic [5:0] funct;
    logic [4:0] unused_shamt;

    always_comb begin
        opcode       = instr[31:26];
        rs_idx       = instr[25:21];
        rt_idx       = instr[20:16];
        rd_idx       = instr[15:11];
        unused_shamt = instr[10:6];
        funct        = instr[5:0];
        is_add       = (opcode == OPC_REGFMT) && (funct == FUNC_ADD);
    end

endmodule

// File: rtl/mini_rcore_regfile.sv
module mini_rcore_regfile #(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 32,
    localparam int REG_AW = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] rs_addr,
    output logic [DATA_W-1:0] rs_data,
    input  logic [REG_AW-1:0] rt_addr,
    output logic [DATA_W-1:0] rt_data,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dbg_we,
    input  logic [REG_AW-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata
);

    logic [DATA_W-1:0] regs [REG_CNT];

    for (genvar i = 0; i < REG_CNT; i++) begin : g_cell
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cell_q <= '0;
                else if (wr_en && wr_addr == REG_AW'(i))
                    cell_q <= wr_data;
                else if (dbg_we && dbg_addr == REG_AW'(i))
                    cell_q <= dbg_wdata;
            end
            assign regs[i] = cell_q;
        end
    end

    assign rs_data   = regs[rs_addr];
    assign rt_data   = regs[rt_addr];
    assign dbg_rdata = regs[dbg_addr];

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (rs_addr == '0) |-> (rs_data == '0)); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=> (regs[$past(wr_addr)] == $past(wr_data))); // R2

endmodule

// File: rtl/mini_rcore_ctrl.sv
module mini_rcore_ctrl
    import mini_rcore_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               imem_ready,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic               imem_req,
    output logic [DATA_W-1:0]  imem_addr,
    output logic [INSTR_W-1:0] instr_q,
    input  logic               is_add,
    input  logic [DATA_W-1:0]  rs_data,
    input  logic [DATA_W-1:0]  rt_data,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wr_data,
    input  logic               pc_set_en,
    input  logic [DATA_W-1:0]  pc_set_val,
    output logic [DATA_W-1:0]  pc_q,
    output logic               halt,
    output logic               fault
);

    core_state_e       state_q, state_d;
    logic [DATA_W-1:0] opa_q, opb_q;
    logic              pc_high;

    assign pc_high = pc_q[DATA_W-1];

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_FETCH;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                if (pc_high)
                    state_d = ST_FAULTED;
                else if (imem_ready)
                    state_d = ST_ADVANCE;
            end
            ST_ADVANCE: state_d = ST_DECODE;
            ST_DECODE:  state_d = is_add ? ST_EXECUTE : ST_HALTED;
            ST_EXECUTE: state_d = ST_FETCH;
            ST_HALTED:  state_d = ST_HALTED;
            ST_FAULTED: state_d = ST_FAULTED;
            default:    state_d = ST_HALTED;
        endcase
    end

    // outputs
    always_comb begin
        imem_req = (state_q == ST_FETCH) && !pc_high;
        wr_en    = (state_q == ST_EXECUTE);
        halt     = (state_q == ST_HALTED);
        fault    = (state_q == ST_FAULTED);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            instr_q <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
        end else begin
            if (pc_set_en)
                pc_q <= pc_set_val;
            else if (state_q == ST_ADVANCE)
                pc_q <= pc_q + DATA_W'(PC_STEP);
            if (state_q == ST_FETCH && !pc_high && imem_ready)
                instr_q <= imem_rdata;
            if (state_q == ST_DECODE) begin
                opa_q <= rs_data;
                opb_q <= rt_data;
            end
        end
    end

    assign wr_data   = opa_q + opb_q;
    assign imem_addr = pc_q;

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADVANCE && !pc_set_en) |=> (pc_q == $past(pc_q) + DATA_W'(PC_STEP))); // R5

    AST_PC_WAIT: assert property (@(posedge clk) disable iff (rst)
        (imem_req && !imem_ready && !pc_set_en) |=> $stable(pc_q)); // R5

    AST_NO_HIGH_FETCH: assert property (@(posedge clk) disable iff (rst)
        imem_req |-> !imem_addr[DATA_W-1]); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halt |=> (halt && !imem_req && !fault)); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault |=> (fault && !imem_req && !halt)); // R8

    AST_NO_WRITE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (halt || fault) |-> !wr_en); // R7

endmodule

// File: rtl/mini_rcore.sv
module mini_rcore
    import mini_rcore_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 32,
    localparam int REG_AW = $clog2(REG_CNT),
    localparam int SEL_W  = REG_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    output logic               imem_req,
    output logic [DATA_W-1:0]  imem_addr,
    input  logic               imem_ready,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic               dbg_we,
    input  logic [SEL_W-1:0]   dbg_sel,
    input  logic [DATA_W-1:0]  dbg_wdata,
    output logic [DATA_W-1:0]  dbg_rdata,
    output logic               halt,
    output logic               fault
);

    localparam logic [SEL_W-1:0] SEL_PC = SEL_W'(REG_CNT);
    localparam logic [SEL_W-1:0] SEL_HI = SEL_W'(REG_CNT + 1);
    localparam logic [SEL_W-1:0] SEL_LO = SEL_W'(REG_CNT + 2);

    logic [INSTR_W-1:0] instr_q;
    logic [FIELD_W-1:0] rs_idx, rt_idx, rd_idx;
    logic               is_add;
    logic [DATA_W-1:0]  rs_data, rt_data, wr_data, pc_q, gpr_rdata;
    logic               wr_en, gpr_hit, gpr_we, pc_set_en;
    logic [DATA_W-1:0]  hi_q, lo_q;

    assign gpr_hit   = dbg_sel < SEL_W'(REG_CNT);
    assign gpr_we    = dbg_we && gpr_hit;
    assign pc_set_en = dbg_we && (dbg_sel == SEL_PC);

    mini_rcore_decode u_decode (
        .instr  (instr_q),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .rd_idx (rd_idx),
        .is_add (is_add)
    );

    mini_rcore_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .rs_addr   (REG_AW'(rs_idx)),
        .rs_data   (rs_data),
        .rt_addr   (REG_AW'(rt_idx)),
        .rt_data   (rt_data),
        .wr_en     (wr_en),
        .wr_addr   (REG_AW'(rd_idx)),
        .wr_data   (wr_data),
        .dbg_we    (gpr_we),
        .dbg_addr  (dbg_sel[REG_AW-1:0]),
        .dbg_wdata (dbg_wdata),
        .dbg_rdata (gpr_rdata)
    );

    mini_rcore_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .imem_ready (imem_ready),
        .imem_rdata (imem_rdata),
        .imem_req   (imem_req),
        .imem_addr  (imem_addr),
        .instr_q    (instr_q),
        .is_add     (is_add),
        .rs_data    (rs_data),
        .rt_data    (rt_data),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .pc_set_en  (pc_set_en),
        .pc_set_val (dbg_wdata),
        .pc_q       (pc_q),
        .halt       (halt),
        .fault      (fault)
    );

    // hi/lo: visible, never written by the add subset
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end
    end

    always_comb begin
        dbg_rdata = '0;
        if (gpr_hit)
            dbg_rdata = gpr_rdata;
        else if (dbg_sel == SEL_PC)
            dbg_rdata = pc_q;
        else if (dbg_sel == SEL_HI)
            dbg_rdata = hi_q;
        else if (dbg_sel == SEL_LO)
            dbg_rdata = lo_q;
    end

    AST_REQ_ONLY_FETCHING: assert property (@(posedge clk) disable iff (rst)
        imem_req |-> (!halt && !fault)); // R7

endmodule

// File: tb/mini_rcore_tb.sv
`timescale 1ns/1ps
module mini_rcore_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_req;
    logic [31:0] imem_addr;
    logic        imem_ready;
    logic [31:0] imem_rdata;
    logic        dbg_we = 1'b0;
    logic [5:0]  dbg_sel = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        halt, fault;

    logic        rdy_en = 1'b0;
    logic        stall_mode = 1'b0;
    logic [31:0] cyc = '0;
    logic [31:0] mem [64];
    int          n_tests = 0;
    int          n_fail  = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign imem_ready = rdy_en && (!stall_mode || cyc[1]);
    assign imem_rdata = mem[imem_addr[7:2]];

    mini_rcore dut_i (
        .clk(clk), .rst(rst),
        .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_ready(imem_ready), .imem_rdata(imem_rdata),
        .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .halt(halt), .fault(fault)
    );

    function automatic logic [31:0] enc(input int op, input int rs, input int rt,
                                        input int rd, input int sh, input int fn);
        return {op[5:0], rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rdy_en = 1'b0; stall_mode = 1'b0; dbg_we = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic dbg_write(input int sel, input logic [31:0] val);
        @(negedge clk);
        dbg_we = 1'b1; dbg_sel = sel[5:0]; dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic dbg_read(input int sel, output logic [31:0] val);
        @(negedge clk);
        dbg_sel = sel[5:0];
        #1 val = dbg_rdata;
    endtask

    task automatic run_prog(input string req);
        bit done = 0;
        @(negedge clk);
        rdy_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (halt || fault) begin done = 1; break; end
        end
        rdy_en = 1'b0;
        chk({req, " stopped"}, {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        chk("R1 pc", imem_addr, 32'h0);
        chk("R1 req", {31'd0, imem_req}, 32'd1);
        chk("R1 halt/fault", {30'd0, halt, fault}, 32'd0);
        dbg_read(5, v);  chk("R1 gpr5", v, 32'h0);
        dbg_read(32, v); chk("R10 pc via sel 32", v, 32'h0);
        dbg_read(33, v); chk("R9 hi", v, 32'h0);
        dbg_read(34, v); chk("R9 lo", v, 32'h0);
    endtask

    task automatic t_example_add();
        logic [31:0] v;
        do_reset();
        dbg_write(8, 32'd5);
        dbg_write(9, 32'd7);
        mem[0] = 32'h0109_5020;
        run_prog("R2");
        dbg_read(10, v); chk("R2 r10=r8+r9", v, 32'd12);
        chk("R7 halt after add", {31'd0, halt}, 32'd1);
        dbg_read(32, v); chk("R5 pc after two words", v, 32'd8);
        dbg_read(33, v); chk("R9 hi unchanged", v, 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        do_reset();
        dbg_write(3, 32'd10);
        mem[0] = enc(0, 3, 3, 3, 0, 32);
        mem[1] = enc(0, 3, 3, 4, 0, 32);
        mem[2] = enc(0, 4, 3, 4, 0, 32);
        run_prog("R3");
        dbg_read(3, v); chk("R3 rd=rs=rt", v, 32'd20);
        dbg_read(4, v); chk("R3 rd=rs", v, 32'd60);
        dbg_read(32, v); chk("R5 pc", v, 32'd16);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        do_reset();
        dbg_write(1, 32'hFFFF_FFFF);
        dbg_write(2, 32'd2);
        mem[0] = enc(0, 1, 2, 5, 31, 32);
        mem[1] = enc(0, 2, 2, 6, 7, 32);
        run_prog("R4");
        dbg_read(5, v); chk("R4 wrap", v, 32'd1);
        dbg_read(6, v); chk("R4 shamt ignored", v, 32'd4);
        chk("R4 no fault", {31'd0, fault}, 32'd0);
    endtask

    task automatic t_zero_reg();
        logic [31:0] v;
        do_reset();
        dbg_write(0, 32'h1234);
        dbg_read(0, v); chk("R6 debug write to r0", v, 32'h0);
        dbg_write(1, 32'd11);
        dbg_write(2, 32'd22);
        mem[0] = enc(0, 1, 2, 0, 0, 32);
        mem[1] = enc(0, 0, 1, 6, 0, 32);
        run_prog("R6");
        dbg_read(0, v); chk("R6 add to r0", v, 32'h0);
        dbg_read(6, v); chk("R6 r0 as source", v, 32'd11);
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        do_reset();
        dbg_write(1, 32'd3);
        dbg_write(7, 32'h55);
        mem[0] = enc(0, 1, 1, 7, 0, 34);
        run_prog("R7");
        dbg_read(7, v); chk("R7 bad funct rd kept", v, 32'h55);
        dbg_read(32, v); chk("R7 pc past word", v, 32'd4);
        repeat (5) @(negedge clk);
        chk("R7 halt held, no req", {30'd0, halt, imem_req}, 32'd2);
        do_reset();
        dbg_write(1, 32'd3);
        mem[0] = 32'h2000_0000 | enc(0, 1, 1, 8, 0, 32);
        run_prog("R7");
        dbg_read(8, v); chk("R7 bad opcode rd kept", v, 32'h0);
        chk("R7 halt not fault", {30'd0, halt, fault}, 32'd2);
    endtask

    task automatic t_fault();
        logic [31:0] v;
        do_reset();
        dbg_write(32, 32'h7FFF_FFFC);
        dbg_write(1, 32'd9);
        mem[63] = enc(0, 1, 1, 2, 0, 32);
        run_prog("R8");
        chk("R8 fault set, halt low", {30'd0, halt, fault}, 32'd1);
        dbg_read(2, v); chk("R8 last legal word ran", v, 32'd18);
        dbg_read(32, v); chk("R8 pc at boundary", v, 32'h8000_0000);
        repeat (4) @(negedge clk);
        chk("R8 no request", {31'd0, imem_req}, 32'd0);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        do_reset();
        dbg_write(4, 32'd100);
        mem[0] = enc(0, 4, 4, 9, 0, 32);
        mem[1] = enc(0, 9, 4, 9, 0, 32);
        repeat (6) @(negedge clk);
        chk("R5 pc holds, ready low", imem_addr, 32'd0);
        chk("R5 req held", {31'd0, imem_req}, 32'd1);
        stall_mode = 1'b1;
        run_prog("R5");
        dbg_read(9, v); chk("R5 stalled result", v, 32'd300);
        dbg_read(32, v); chk("R5 stalled pc", v, 32'd12);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_example_add();
        t_alias();
        t_wrap();
        t_zero_reg();
        t_illegal();
        t_fault();
        t_stall();
        finish_up();
    end

endmodule